// File: doc/BRIEF.md
# Clock frequency measurement counter

This block estimates the rate of one clock chosen from a bank of internal clocks by counting its rising edges during a gate interval timed by a reference clock. Software picks a source, loads a gate length expressed in reference cycles, waits for the busy flag to drop and then reads the captured edge count. With a 19.2 MHz reference and a gate of 19200 cycles the gate spans 1 ms, so the rate in Hz is the count multiplied by 1000.

The edge counter lives in the domain of the measured clock. A run level crosses into that domain through a two-flop synchronizer. The counter's own running indication crosses back the same way. The reference side copies the frozen count only after it has seen that indication rise and then fall, so the multi-bit value is already stable when it is sampled. A dead or missing source can never confirm that it has stopped. A bounded drain wait covers that case and raises a timeout flag.

The controller has four states. IDLE moves to GATE on a start (a nonzero gate-length write). GATE moves to DRAIN when the gate reaches zero. DRAIN moves to DONE on capture (the stop has been confirmed) or on expiry (the drain timer has run out). DONE moves to GATE on a new start, or to IDLE on a control write without kill. A kill from any state goes to IDLE.

Top module: `fm_freq_meter`

## Requirements
- R1: After reset the control register reads with busy (bit 7), timeout (bit 8) and overflow (bit 9) all clear, and the gate register and the count register both read zero.
- R2: A write of a nonzero value N to the gate register (address 1) while the block is idle or done starts a measurement. In the cycle after the write the gate register reads N and busy reads 1. From then on it drops by one per reference cycle.
- R3: The source index is six bits: the low four bits come from control bits 3:0 and the high two bits from control bits 13:12. Both fields read back, index k selects input `meas_clks[k]`, and index 0 selects a constant low level.
- R4: After a measurement the count register (address 2) holds the number of rising edges of the selected clock during the gate, within plus or minus 3.
- R5: Busy stays 1 in the first cycle the gate register reads zero. It falls only once the count is captured or the drain wait expires.
- R6: A control write (address 0) with kill (bit 5) set aborts any measurement. One cycle later busy is 0, the gate register reads 0 and the count register reads 0.
- R7: A gate register write while busy is ignored, and the gate keeps counting down from its live value.
- R8: The edge counter saturates at its maximum value. The overflow flag (control bit 9) is then 1 along with the captured all-ones count. Otherwise it is 0.
- R9: If the selected domain does not confirm that it has stopped within TMO_CYC reference cycles after the gate ends, busy clears, the timeout flag (control bit 8) is set and the count reads 0.
- R10: A control write without kill while in DONE returns the block to IDLE. It clears the timeout and overflow flags and leaves the count register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| meas_clks | input | SRC_N | Bank of clocks that can be measured |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 gate, 2 count |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |

## Verification
A controller stuck in GATE or DRAIN shows up as busy never falling. A wrong gate decrement shows in the live gate readback in the very next cycle. A missed or early capture appears as a count far from the expected edge total, or as a spurious timeout, as soon as busy drops, typically within a few tens of reference cycles. A saturation fault that wraps instead of holding shows a small count with the overflow flag set in the first measurement whose gate is longer than the counter range.

// File: rtl/fm_pkg.sv
package fm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } fm_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_GATE = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;

    localparam int CTL_KILL   = 5;
    localparam int CTL_BUSY   = 7;
    localparam int CTL_TMO    = 8;
    localparam int CTL_OVF    = 9;
    localparam int CTL_HI_LSB = 12;
endpackage

// File: rtl/fm_sync2.sv
module fm_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q      <= 1'b0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/fm_window.sv
module fm_window #(
    parameter int WIN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [WIN_W-1:0] load_val,
    input  logic             dec,
    output logic [WIN_W-1:0] cnt,
    output logic             last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (clr)                   cnt <= '0;
        else if (load)                  cnt <= load_val;
        else if (dec && cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign last = (cnt == WIN_W'(1));

    AST_WIN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !clr && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R2
endmodule

// File: rtl/fm_edge_cnt.sv
module fm_edge_cnt #(
    parameter int CNT_W = 20
) (
    input  logic             mclk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             ack
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic en_m;

    fm_sync2 u_run_sync (.clk(mclk), .rst_n(rst_n), .d(run), .q(en_m));

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
            ack <= 1'b0;
        end else begin
            ack <= en_m;
            if (en_m && !ack) begin
                cnt <= CNT_W'(1);
                ovf <= 1'b0;
            end else if (en_m) begin
                if (cnt == CNT_MAX) ovf <= 1'b1;
                else                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge mclk) disable iff (!rst_n)
        ovf |-> (cnt == CNT_MAX)); // R8
endmodule

// File: rtl/fm_ctrl_fsm.sv
module fm_ctrl_fsm
    import fm_pkg::*;
#(
    parameter int TMO_CYC = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      kill,
    input  logic      ctl_wr,
    input  logic      win_last,
    input  logic      ack_r,
    output fm_state_e state,
    output logic      run,
    output logic      busy,
    output logic      capture,
    output logic      expire
);
    localparam int TMO_W = $clog2(TMO_CYC + 1);

    fm_state_e        nxt;
    logic             seen_q;
    logic [TMO_W-1:0] tmo_cnt;
    logic             tmo_hit;

    assign tmo_hit = (tmo_cnt == TMO_W'(TMO_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (kill) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (start) nxt = ST_GATE;
                ST_GATE:  if (win_last) nxt = ST_DRAIN;
                ST_DRAIN: if (capture || expire) nxt = ST_DONE;
                ST_DONE: begin
                    if (start)       nxt = ST_GATE;
                    else if (ctl_wr) nxt = ST_IDLE;
                end
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            tmo_cnt <= '0;
        end else if (state == ST_GATE || state == ST_DRAIN) begin
            if (ack_r)              seen_q  <= 1'b1;
            if (state == ST_DRAIN)  tmo_cnt <= tmo_cnt + 1'b1;
        end else begin
            seen_q  <= 1'b0;
            tmo_cnt <= '0;
        end
    end

    always_comb begin
        run     = (state == ST_GATE);
        busy    = (state == ST_GATE) || (state == ST_DRAIN);
        capture = (state == ST_DRAIN) && seen_q && !ack_r;
        expire  = (state == ST_DRAIN) && !capture && tmo_hit;
    end

    AST_KILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (state == ST_IDLE)); // R6
endmodule

// File: rtl/fm_freq_meter.sv
module fm_freq_meter
    import fm_pkg::*;
#(
    parameter int SRC_N   = 40,
    parameter int LO_W    = 4,
    parameter int HI_W    = 2,
    parameter int WIN_W   = 20,
    parameter int CNT_W   = 20,
    parameter int TMO_CYC = 32,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  meas_clks,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int SEL_W = LO_W + HI_W;

    fm_state_e        state;
    logic             run, busy, capture, expire;
    logic             start, kill, ctl_wr;
    logic [WIN_W-1:0] win_cnt;
    logic             win_last;
    logic [SEL_W-1:0] sel_q;
    logic             src_clk;
    logic [CNT_W-1:0] cnt_m;
    logic             ovf_m, ack_m, ack_r;
    logic [CNT_W-1:0] count_q;
    logic             ovf_q, tmo_q;
    wire              unused_wdata = ^reg_wdata;

    assign kill   = reg_wr && reg_addr == ADDR_CTRL && reg_wdata[CTL_KILL];
    assign ctl_wr = reg_wr && reg_addr == ADDR_CTRL && !reg_wdata[CTL_KILL];
    assign start  = reg_wr && reg_addr == ADDR_GATE && reg_wdata[WIN_W-1:0] != '0
                    && (state == ST_IDLE || state == ST_DONE);

    always_comb begin
        src_clk = 1'b0;
        for (int i = 1; i < SRC_N; i++)
            if (sel_q == SEL_W'(i)) src_clk = meas_clks[i];
    end

    fm_ctrl_fsm #(.TMO_CYC(TMO_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .kill(kill), .ctl_wr(ctl_wr),
        .win_last(win_last), .ack_r(ack_r), .state(state), .run(run),
        .busy(busy), .capture(capture), .expire(expire)
    );

    fm_window #(.WIN_W(WIN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .clr(kill), .load(start),
        .load_val(reg_wdata[WIN_W-1:0]), .dec(state == ST_GATE),
        .cnt(win_cnt), .last(win_last)
    );

    fm_edge_cnt #(.CNT_W(CNT_W)) u_edge (
        .mclk(src_clk), .rst_n(rst_n), .run(run),
        .cnt(cnt_m), .ovf(ovf_m), .ack(ack_m)
    );

    fm_sync2 u_ack_sync (.clk(clk), .rst_n(rst_n), .d(ack_m), .q(ack_r));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            count_q <= '0;
            ovf_q   <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            if (ctl_wr && !busy)
                sel_q <= {reg_wdata[CTL_HI_LSB +: HI_W], reg_wdata[LO_W-1:0]};
            if (kill) begin
                count_q <= '0;
                ovf_q   <= 1'b0;
                tmo_q   <= 1'b0;
            end else if (capture) begin
                count_q <= cnt_m;
                ovf_q   <= ovf_m;
                tmo_q   <= 1'b0;
            end else if (expire) begin
                count_q <= '0;
                ovf_q   <= 1'b0;
                tmo_q   <= 1'b1;
            end else if (ctl_wr && state == ST_DONE) begin
                ovf_q   <= 1'b0;
                tmo_q   <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[LO_W-1:0]              = sel_q[LO_W-1:0];
                reg_rdata[CTL_HI_LSB +: HI_W]    = sel_q[SEL_W-1:LO_W];
                reg_rdata[CTL_BUSY]              = busy;
                reg_rdata[CTL_TMO]               = tmo_q;
                reg_rdata[CTL_OVF]               = ovf_q;
            end
            ADDR_GATE: reg_rdata[WIN_W-1:0] = win_cnt;
            ADDR_CNT:  reg_rdata[CNT_W-1:0] = count_q;
            default:   reg_rdata = '0;
        endcase
    end

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (win_cnt == '0)); // R5
    AST_TMO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q |-> (count_q == '0 && !ovf_q)); // R9
endmodule

// File: tb/fm_freq_meter_tb.sv
`timescale 1ns/1ps
module fm_freq_meter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 10;

    typedef struct packed {
        logic [5:0]  sel;
        logic [19:0] win;
        logic [15:0] exp_cnt;
        logic        exp_ovf;
    } vec_t;

    // periods: src6 20ns, src20 4ns, src39 6ns, src17 8ns; ref 10ns
    localparam vec_t VECS [5] = '{
        '{sel: 6'd6,  win: 20'd100, exp_cnt: 16'd50,   exp_ovf: 1'b0},
        '{sel: 6'd20, win: 20'd100, exp_cnt: 16'd250,  exp_ovf: 1'b0},
        '{sel: 6'd39, win: 20'd60,  exp_cnt: 16'd100,  exp_ovf: 1'b0},
        '{sel: 6'd17, win: 20'd80,  exp_cnt: 16'd100,  exp_ovf: 1'b0},
        '{sel: 6'd20, win: 20'd500, exp_cnt: 16'd1023, exp_ovf: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] meas_clks = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #10 meas_clks[6]  = ~meas_clks[6];
    always #2  meas_clks[20] = ~meas_clks[20];
    always #3  meas_clks[39] = ~meas_clks[39];
    always #4  meas_clks[17] = ~meas_clks[17];

    fm_freq_meter #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .meas_clks(meas_clks), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] ctl_word(input logic [5:0] s);
        return {18'd0, s[5:4], 8'd0, s[3:0]};
    endfunction

    task automatic wait_idle();
        logic [31:0] d;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            rd(2'd0, d);
            if (!d[7]) break;
        end
    endtask

    task automatic measure(input logic [5:0] s, input logic [19:0] w);
        wr(2'd0, 32'h20);
        wr(2'd0, ctl_word(s));
        wr(2'd1, {12'd0, w});
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, c;
        int diff;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d);
        check(d[9:7] == 3'b000, "R1 flags", int'(d[9:7]), 0);
        rd(2'd1, d);
        check(d == 0, "R1 gate", int'(d), 0);
        rd(2'd2, d);
        check(d == 0, "R1 count", int'(d), 0);

        // R3 split index readback
        wr(2'd0, ctl_word(6'd39));
        rd(2'd0, d);
        check(d[3:0] == 4'd7 && d[13:12] == 2'd2, "R3 readback", int'({d[13:12], d[3:0]}), 39);

        // table walk: R3 R4 R8
        foreach (VECS[i]) begin
            measure(VECS[i].sel, VECS[i].win);
            rd(2'd2, c);
            rd(2'd0, d);
            diff = int'(c) - int'(VECS[i].exp_cnt);
            check(diff >= -3 && diff <= 3, "R4 count", int'(c), int'(VECS[i].exp_cnt));
            check(d[9] == VECS[i].exp_ovf, "R8 overflow", int'(d[9]), int'(VECS[i].exp_ovf));
            if (VECS[i].exp_ovf) check(c == 32'd1023, "R8 saturate", int'(c), 1023);
        end

        // R10 control write in DONE clears flags, keeps count
        wr(2'd0, ctl_word(6'd6));
        rd(2'd0, d);
        check(d[9] == 1'b0 && d[7] == 1'b0, "R10 flags", int'(d[9:7]), 0);
        rd(2'd2, c);
        check(c == 32'd1023, "R10 count kept", int'(c), 1023);

        // R2 start and live countdown
        wr(2'd0, 32'h20);
        wr(2'd0, ctl_word(6'd6));
        wr(2'd1, 32'd50);
        rd(2'd1, d);
        check(d == 32'd50, "R2 load", int'(d), 50);
        rd(2'd0, c);
        check(c[7] == 1'b1, "R2 busy", int'(c[7]), 1);
        @(negedge clk);
        rd(2'd1, d);
        check(d == 32'd49, "R2 decrement", int'(d), 49);

        // R7 gate write while busy ignored
        wr(2'd1, 32'd999);
        rd(2'd1, d);
        check(d == 32'd47, "R7 ignored", int'(d), 47);

        // R5 busy held once gate reaches zero
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            rd(2'd1, d);
            if (d == 0) break;
        end
        rd(2'd0, c);
        check(c[7] == 1'b1, "R5 busy at zero", int'(c[7]), 1);
        wait_idle();
        rd(2'd2, c);
        diff = int'(c) - 25;
        check(diff >= -3 && diff <= 3, "R5 count", int'(c), 25);

        // R6 kill mid-measurement
        wr(2'd0, 32'h20);
        wr(2'd0, ctl_word(6'd20));
        wr(2'd1, 32'd300);
        repeat (10) @(negedge clk);
        wr(2'd0, 32'h20);
        rd(2'd0, d);
        check(d[7] == 1'b0, "R6 busy", int'(d[7]), 0);
        rd(2'd1, d);
        check(d == 0, "R6 gate", int'(d), 0);
        rd(2'd2, d);
        check(d == 0, "R6 count", int'(d), 0);

        // R9 timeout on dead source (index 0)
        measure(6'd0, 20'd20);
        rd(2'd0, d);
        check(d[7] == 1'b0, "R9 busy", int'(d[7]), 0);
        check(d[8] == 1'b1, "R9 timeout", int'(d[8]), 1);
        rd(2'd2, c);
        check(c == 0, "R9 count", int'(c), 0);

        // R10 again: control write clears timeout
        wr(2'd0, ctl_word(6'd0));
        rd(2'd0, d);
        check(d[8] == 1'b0, "R10 timeout cleared", int'(d[8]), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule